// File: doc/BRIEF.md
# I2C Byte-Addressed EEPROM Target

This block is an I2C target that behaves like a small serial EEPROM with byte-wide words. It runs from a fast system clock. SCL and SDA are treated as asynchronous inputs and sampled through synchronisers. SDA is driven only by an open-drain pull-down enable. The block recognises start, repeated start and stop conditions and answers to a seven-bit device address. That address is formed from a fixed device-type nibble and three strap inputs. Storage is an internal byte array of 256 entries, or of 128 entries when the `MEM_BYTES` parameter selects the smaller variant.

A single word-address counter persists between transfers and wraps at the end of the array. This counter supports four kinds of access:
- A write transfer loads the counter and, optionally, stores bytes.
- A read with no address phase continues from wherever the last access ended.
- A random read is made by a write that carries only the word address, followed by a repeated start.
- A read goes on streaming bytes for as long as the controller acknowledges them.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The address byte after a start is matched against `1010` followed by `addr_sel_i[2:0]`, most significant bit first. Its least significant bit selects the direction: 1 for read, 0 for write. On a match the block pulls SDA low during the ninth clock.
- R2: When the address byte does not match, the block gives no acknowledge. It drives nothing and changes no memory or counter until the next start, whatever bytes follow.
- R3: In a write transfer, the first byte after the address is taken as the word address. It loads the address counter and is acknowledged. In the 128-byte variant its top bit is ignored.
- R4: Each further byte of a write transfer is stored at the counter location and acknowledged. The counter then advances by one.
- R5: A read that follows a read or write of location n returns the byte at n+1.
- R6: A write carrying only the word address, then a repeated start and a read address byte, returns the byte at that word address.
- R7: After each byte it sends, the block samples the controller's ninth bit. Low means send the next location. High means release SDA and stay quiet until a start or stop.
- R8: The counter wraps from the last location (255, or 127 in the small variant) to 0, and streaming continues across the wrap.
- R9: A start or stop seen at any point abandons the byte in progress. A start always begins a new address byte. An interrupted write byte is not stored.
- R10: SDA is never driven high. The pull-down enable rises only while SCL is low. Data leaves most significant bit first.
- R11: After reset the pull-down is released and the counter is 0. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench places two targets on the same bus: a 256-byte target and a 128-byte target. Together they cover wrap at both boundaries and the case of a third address that nobody claims. A counter that wrapped at the wrong width, or that failed to advance after a NACKed byte, would return the wrong byte on the following address-free read. A state machine that did not abort on a start in mid-byte would misread the next address. A design that committed partial bytes on a stop would corrupt a location that is then read back. A target that acknowledged a foreign address, or stored its data, shows up as an ACK seen on the bus or as a changed byte.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_RNEXT
  } eep_state_e;

endpackage

// File: rtl/eep_bus_sync.sv
// Reset release synchroniser, two-flop line synchronisers and
// SCL edge / start / stop detection.
module eep_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_ns,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] rst_pipe_q;
  logic [1:0] meta_q;   // {scl, sda}
  logic [1:0] sync_q;
  logic [1:0] dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_ns = rst_pipe_q[1];

  // idle bus level is high on both lines
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      meta_q <= 2'b11;
      sync_q <= 2'b11;
      dly_q  <= 2'b11;
    end else begin
      meta_q <= {scl_i, sda_i};
      sync_q <= meta_q;
      dly_q  <= sync_q;
    end
  end

  assign scl_s     = sync_q[1];
  assign sda_s     = sync_q[0];
  assign scl_rise  = scl_s & ~dly_q[1];
  assign scl_fall  = ~scl_s & dly_q[1];
  assign start_det = scl_s & dly_q[1] & dly_q[0] & ~sda_s;
  assign stop_det  = scl_s & dly_q[1] & ~dly_q[0] & sda_s;

endmodule

// File: rtl/eep_store.sv
// Byte storage: one write port, one asynchronous read port.
module eep_store #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cell_q[addr] <= wdata;
  end

  assign rdata = cell_q[addr];

endmodule

// File: rtl/eep_ctrl.sv
// Protocol engine: address match, word-address load, write and
// read streaming with a persistent wrapping counter.
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [2:0]    addr_sel,
  input  logic [7:0]    rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          sda_oe,
  output eep_state_e    state
);

  localparam logic [3:0] BYTE_BITS = 4'd8;
  localparam logic [3:0] LAST_BIT  = 4'd7;

  eep_state_e    state_q, state_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          rw_q, rw_d;
  logic          oe_q, oe_d;
  logic          we_c;
  logic          dev_hit;

  assign dev_hit = (sh_q[7:1] == {DEV_TYPE, addr_sel});

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    we_c    = 1'b0;
    if (start_det) begin
      state_d = ST_DEV;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bit_q != BYTE_BITS) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == BYTE_BITS) begin
            bit_d = '0;
            if (state_q == ST_DEV) begin
              if (dev_hit) begin
                rw_d    = sh_q[0];
                oe_d    = 1'b1;
                state_d = ST_DEV_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_WADDR) begin
              cnt_d   = sh_q[AW-1:0];
              oe_d    = 1'b1;
              state_d = ST_WADDR_ACK;
            end else begin
              we_c    = 1'b1;
              cnt_d   = cnt_q + AW'(1);
              oe_d    = 1'b1;
              state_d = ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            bit_d = '0;
            if (state_q == ST_DEV_ACK && rw_q) begin
              sh_d    = rdata;
              oe_d    = ~rdata[7];
              state_d = ST_RDATA;
            end else if (state_q == ST_DEV_ACK) begin
              state_d = ST_WADDR;
            end else begin
              state_d = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_q == LAST_BIT) begin
              oe_d    = 1'b0;
              bit_d   = '0;
              cnt_d   = cnt_q + AW'(1);
              state_d = ST_RACK;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              oe_d  = ~sh_q[6];
              bit_d = bit_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) state_d = sda_s ? ST_IDLE : ST_RNEXT;
        end
        ST_RNEXT: begin
          if (scl_fall) begin
            sh_d    = rdata;
            oe_d    = ~rdata[7];
            bit_d   = '0;
            state_d = ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
    end
  end

  assign mem_we    = we_c;
  assign mem_addr  = cnt_q;
  assign mem_wdata = sh_q;
  assign sda_oe    = oe_q;
  assign state     = state_q;

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter int MEM_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_sel_i,
  output logic       sda_oe_o
);

  localparam int AW = $clog2(MEM_BYTES);

  logic          rst_ns;
  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata;
  eep_state_e    state;

  eep_bus_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .rst_ns    (rst_ns),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eep_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .addr_sel  (addr_sel_i),
    .rdata     (mem_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sda_oe    (sda_oe_o),
    .state     (state)
  );

  eep_store #(.DEPTH(MEM_BYTES), .AW(AW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe_o,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input eep_state_e state
);

  // the pull-down may only begin while SCL was low
  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !$past(scl_s));

  // a start always releases the line
  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe_o);

  // a stop always returns the engine to idle
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state == ST_IDLE);

  // the line is pulled only in acknowledge or read-data phases
  assert_pull_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (state == ST_DEV_ACK || state == ST_WADDR_ACK ||
                  state == ST_WDATA_ACK || state == ST_RDATA));

endmodule

bind i2c_eeprom_target eep_checker u_eep_checker (
  .clk       (clk),
  .rst_n     (rst_ns),
  .sda_oe_o  (sda_oe_o),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state     (state)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;

  localparam int Q = 10;               // quarter SCL period in clocks
  localparam logic [2:0] SEL_A = 3'b101; // 256-byte target
  localparam logic [2:0] SEL_B = 3'b011; // 128-byte target
  localparam logic [2:0] SEL_X = 3'b111; // nobody
  localparam int NVEC = 8;
  // {word address, data}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h00A5, 16'h013C, 16'h027E, 16'hFE81,
    16'hFFC3, 16'h405A, 16'h4196, 16'h200F
  };

  logic clk;
  logic rst_n;
  logic m_scl;
  logic m_low;
  logic oe_a;
  logic oe_b;
  logic sda_bus;
  int   errors;
  int   checks;
  logic [7:0] model_a [256];
  logic [7:0] model_b [128];

  assign sda_bus = ~(m_low | oe_a | oe_b);

  i2c_eeprom_target i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_sel_i(SEL_A), .sda_oe_o(oe_a));

  i2c_eeprom_target #(.MEM_BYTES(128)) i_i2c_eeprom_target_small (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_sel_i(SEL_B), .sda_oe_o(oe_b));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    wait_clks(Q); m_low = ~b;
    wait_clks(Q); m_scl = 1'b1;
    wait_clks(2*Q); m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wait_clks(Q); m_low = 1'b0;
    wait_clks(Q); m_scl = 1'b1;
    wait_clks(Q); b = sda_bus;
    wait_clks(Q); m_scl = 1'b0;
  endtask

  task automatic bus_start;
    wait_clks(Q); m_low = 1'b0;
    wait_clks(Q); m_scl = 1'b1;
    wait_clks(Q); m_low = 1'b1;
    wait_clks(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    wait_clks(Q); m_low = 1'b1;
    wait_clks(Q); m_scl = 1'b1;
    wait_clks(Q); m_low = 1'b0;
    wait_clks(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(nb);
    ack = ~nb;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  // start, address byte for write, word address
  task automatic set_addr(input logic [2:0] sel, input logic [7:0] a);
    logic ack;
    bus_start;
    send_byte({4'b1010, sel, 1'b0}, ack);
    chk("R1 write address ack", ack, 1'b1);
    send_byte(a, ack);
    chk("R3 word address ack", ack, 1'b1);
  endtask

  task automatic open_read(input logic [2:0] sel);
    logic ack;
    bus_start;
    send_byte({4'b1010, sel, 1'b1}, ack);
    chk("R1 read address ack", ack, 1'b1);
  endtask

  task automatic write_one(input logic [2:0] sel, input logic [7:0] a, input logic [7:0] d);
    logic ack;
    set_addr(sel, a);
    send_byte(d, ack);
    chk("R4 data ack", ack, 1'b1);
    bus_stop;
    if (sel == SEL_A) model_a[a] = d;
    else model_b[a[6:0]] = d;
  endtask

  task automatic rand_read(input logic [2:0] sel, input logic [7:0] a, output logic [7:0] d);
    set_addr(sel, a);
    open_read(sel);
    recv_byte(d, 1'b0);
    bus_stop;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic ack;
    logic b;
    errors = 0;
    checks = 0;
    m_scl  = 1'b1;
    m_low  = 1'b0;
    rst_n  = 1'b0;
    wait_clks(6);
    rst_n = 1'b1;
    wait_clks(6);
    chk("R11 line released after reset", {oe_a, oe_b}, 2'b00);

    // table: write every vector, then random-read each back
    for (int i = 0; i < NVEC; i++) write_one(SEL_A, VEC[i][15:8], VEC[i][7:0]);
    for (int i = 0; i < NVEC; i++) begin
      rand_read(SEL_A, VEC[i][15:8], d);
      chk("R6 random read", d, VEC[i][7:0]);
    end

    // R5: current read after a write at 0x40 returns 0x41
    write_one(SEL_A, 8'h40, 8'h5A);
    open_read(SEL_A);
    recv_byte(d, 1'b0);
    bus_stop;
    chk("R5 current read after write", d, model_a[8'h41]);

    // R8 / R7: sequential read across the 255 -> 0 wrap
    set_addr(SEL_A, 8'hFE);
    open_read(SEL_A);
    recv_byte(d, 1'b1); chk("R7 seq byte FE", d, model_a[8'hFE]);
    recv_byte(d, 1'b1); chk("R8 seq byte FF", d, model_a[8'hFF]);
    recv_byte(d, 1'b1); chk("R8 seq byte 00 after wrap", d, model_a[8'h00]);
    recv_byte(d, 1'b0); chk("R8 seq byte 01", d, model_a[8'h01]);
    get_bit(b);
    chk("R7 line released after NACK", b, 1'b1);
    bus_stop;
    open_read(SEL_A);
    recv_byte(d, 1'b0);
    bus_stop;
    chk("R5 current read after NACKed read", d, model_a[8'h02]);

    // R4: multi-byte write, then sequential check (MSB-first data, R10)
    set_addr(SEL_A, 8'h80);
    send_byte(8'h11, ack); chk("R4 ack byte 0", ack, 1'b1);
    send_byte(8'h22, ack); chk("R4 ack byte 1", ack, 1'b1);
    send_byte(8'h83, ack); chk("R4 ack byte 2", ack, 1'b1);
    bus_stop;
    set_addr(SEL_A, 8'h80);
    open_read(SEL_A);
    recv_byte(d, 1'b1); chk("R4 stored 80", d, 8'h11);
    recv_byte(d, 1'b1); chk("R4 stored 81", d, 8'h22);
    recv_byte(d, 1'b0); chk("R10 msb-first 82", d, 8'h83);
    bus_stop;

    // R2: foreign address gets no ack and changes nothing
    bus_start;
    send_byte({4'b1010, SEL_X, 1'b0}, ack); chk("R2 no ack foreign address", ack, 1'b0);
    send_byte(8'h40, ack); chk("R2 no ack word address", ack, 1'b0);
    send_byte(8'hEE, ack); chk("R2 no ack data", ack, 1'b0);
    bus_stop;
    rand_read(SEL_A, 8'h40, d);
    chk("R2 memory untouched", d, 8'h5A);

    // R9: start in mid-address-byte, then a clean random read
    bus_start;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    rand_read(SEL_A, 8'h20, d);
    chk("R9 resync after mid-byte start", d, 8'h0F);

    // R9: stop in mid-data-byte stores nothing
    set_addr(SEL_A, 8'h20);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_stop;
    rand_read(SEL_A, 8'h20, d);
    chk("R9 partial byte not stored", d, 8'h0F);

    // R8 small variant: wrap at 127, R3 top word-address bit ignored
    write_one(SEL_B, 8'h7F, 8'h6D);
    write_one(SEL_B, 8'h80, 8'h2B);
    set_addr(SEL_B, 8'h7F);
    open_read(SEL_B);
    recv_byte(d, 1'b1); chk("R8 small byte 7F", d, 8'h6D);
    recv_byte(d, 1'b0); chk("R3 R8 small wrap to 00", d, 8'h2B);
    bus_stop;

    // R11: reset mid-run keeps the array, zeroes the counter
    rst_n = 1'b0;
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(6);
    chk("R11 line released after second reset", {oe_a, oe_b}, 2'b00);
    open_read(SEL_A);
    recv_byte(d, 1'b0);
    bus_stop;
    chk("R11 counter zero after reset", d, model_a[8'h00]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule